// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Binary Counter

This block is a wide synchronous up counter built from a chain of identical 4-bit slices. Each slice holds its own count bits. It can be cleared at once, loaded from a parallel data word, or advanced by one. A slice advances only when two active-high enables are both high: a parallel enable, shared by every slice, and a trickle enable. The trickle enable also gates the slice's terminal-count flag.

The slices share one clock. The terminal-count flag of each slice drives the trickle enable of the next slice, so the carry passes forward combinationally. An upper slice therefore advances for exactly one edge each time every slice below it reaches all ones. The top module exposes the chain as a single counter of `SLICE_W*NUM_SLICES` bits.

All slices are updated together on the rising edge of the one shared clock. An active-low clear acts at once, without waiting for a clock edge. Each slice resolves its inputs in this priority order: clear, then load, then count, then hold.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_n` is low, `count` is zero. The clear takes effect at once, without waiting for a clock edge, and whatever the levels on `load_n`, `cnt_par` and `cnt_trk`.
- R2: On a rising edge with `clr_n` high and `load_n` low, `count` takes the value of `data`, whatever the levels on `cnt_par` and `cnt_trk`.
- R3: On a rising edge with `clr_n` high, `load_n` high, `cnt_par` high and `cnt_trk` high, `count` increases by one.
- R4: On a rising edge with `clr_n` high and `load_n` high, `count` is unchanged if either `cnt_par` or `cnt_trk` is low.
- R5: An increment from the all-ones value wraps `count` to zero.
- R6: `carry_out` is high exactly when `cnt_trk` is high and `count` is all ones. `cnt_par` has no effect on `carry_out`.
- R7: The chained slices behave as one binary counter of `SLICE_W*NUM_SLICES` bits. An upper slice advances by one only on the edge where every lower slice wraps from all ones.
- R8: `carry_out` is combinational. It follows a change on `cnt_trk` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| data | input | SLICE_W*NUM_SLICES | Value to load |
| cnt_par | input | 1 | Parallel count enable, shared by all slices |
| cnt_trk | input | 1 | Trickle enable of the lowest slice |
| count | output | SLICE_W*NUM_SLICES | Current count |
| carry_out | output | 1 | Terminal-count flag of the whole chain |

## Verification
The counter is driven with random mixes of load, clear and the two enables, and compared against a plain wide-integer model. This tells apart a fault in the priority order from a fault in an enable's gating.

Directed cases load values just below a slice boundary (`0x00FF`, `0x0FFF`) and the all-ones word. These show whether the carry reaches the correct upper slice and whether the full counter wraps.

Toggling `cnt_par` and then `cnt_trk` while the count sits at all ones separates the two enables' roles in the terminal flag. A clear asserted between clock edges shows that it acts without waiting for a clock edge.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  localparam int unsigned SLICE_W_DEF = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } slice_op_e;
endpackage

// File: rtl/slice_next.sv
module slice_next
  import cascade_counter_pkg::*;
#(
  parameter int unsigned SLICE_W = SLICE_W_DEF
) (
  input  logic [SLICE_W-1:0] cur,
  input  logic [SLICE_W-1:0] din,
  input  logic               load_n,
  input  logic               en_par,
  input  logic               en_trk,
  output logic [SLICE_W-1:0] nxt
);
  slice_op_e op;

  // load wins over counting; counting needs both enables
  always_comb begin
    if (!load_n)                op = OP_LOAD;
    else if (en_par && en_trk)  op = OP_COUNT;
    else                        op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = cur + SLICE_W'(1);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/slice_term.sv
module slice_term
  import cascade_counter_pkg::*;
#(
  parameter int unsigned SLICE_W = SLICE_W_DEF
) (
  input  logic [SLICE_W-1:0] cur,
  input  logic               en_trk,
  output logic               tc
);
  // no register: the flag follows the trickle enable directly
  assign tc = en_trk && (&cur);
endmodule

// File: rtl/counter_slice.sv
module counter_slice
  import cascade_counter_pkg::*;
#(
  parameter int unsigned SLICE_W = SLICE_W_DEF
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic [SLICE_W-1:0] din,
  input  logic               en_par,
  input  logic               en_trk,
  output logic [SLICE_W-1:0] q,
  output logic               tc
);
  logic [SLICE_W-1:0] q_nxt;

  slice_next #(.SLICE_W(SLICE_W)) u_next (
    .cur    (q),
    .din    (din),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .nxt    (q_nxt)
  );

  slice_term #(.SLICE_W(SLICE_W)) u_term (
    .cur    (q),
    .en_trk (en_trk),
    .tc     (tc)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cascade_counter_pkg::*;
#(
  parameter int unsigned SLICE_W    = SLICE_W_DEF,
  parameter int unsigned NUM_SLICES = 4,
  localparam int unsigned W         = SLICE_W * NUM_SLICES
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] data,
  input  logic         cnt_par,
  input  logic         cnt_trk,
  output logic [W-1:0] count,
  output logic         carry_out
);
  // trk_chain[i] enables slice i; trk_chain[NUM_SLICES] is the chain's flag
  logic [NUM_SLICES:0] trk_chain;

  assign trk_chain[0] = cnt_trk;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    counter_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .din    (data[i*SLICE_W +: SLICE_W]),
      .en_par (cnt_par),
      .en_trk (trk_chain[i]),
      .q      (count[i*SLICE_W +: SLICE_W]),
      .tc     (trk_chain[i+1])
    );
  end

  assign carry_out = trk_chain[NUM_SLICES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic [W-1:0] data,
  input logic         cnt_par,
  input logic         cnt_trk,
  input logic [W-1:0] count,
  input logic         carry_out
);
  // R1
  clear_zero_chk: assert property (@(posedge clk) !clr_n |-> count == '0);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(data));

  // R3 R5 R7
  count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_par && cnt_trk) |=> count == $past(count) + W'(1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_par && cnt_trk)) |=> $stable(count));

  // R6
  flag_max_chk: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == (cnt_trk && (count == '1)));

  // R8
  flag_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !cnt_trk |-> !carry_out);
endmodule

bind cascade_counter cascade_counter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .data      (data),
  .cnt_par   (cnt_par),
  .cnt_trk   (cnt_trk),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/sim_cascade_counter.sv
`timescale 1ns/1ps
module sim_cascade_counter;
  localparam int unsigned SW = 4;
  localparam int unsigned NS = 4;
  localparam int unsigned W  = SW * NS;

  logic         clk = 1'b0;
  logic         clr_n, load_n, cnt_par, cnt_trk;
  logic [W-1:0] data;
  logic [W-1:0] count;
  logic         carry_out;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] model;
  bit done = 0;

  always #10 clk = ~clk;

  cascade_counter #(.SLICE_W(SW), .NUM_SLICES(NS)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data(data),
    .cnt_par(cnt_par), .cnt_trk(cnt_trk), .count(count), .carry_out(carry_out)
  );

  function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic c_n, logic l_n,
                                            logic [W-1:0] d, logic p, logic t);
    if (!c_n)     return '0;
    if (!l_n)     return d;
    if (p && t)   return cur + W'(1);
    return cur;
  endfunction

  function automatic logic exp_flag(logic [W-1:0] cur, logic t);
    return t && (cur == '1);
  endfunction

  task automatic check_cnt(string req, logic [W-1:0] exp);
    total++;
    if (count !== exp) begin
      bad++;
      $display("FAIL %s count act=%h exp=%h", req, count, exp);
    end
  endtask

  task automatic check_flag(string req, logic exp);
    total++;
    if (carry_out !== exp) begin
      bad++;
      $display("FAIL %s carry_out act=%b exp=%b", req, carry_out, exp);
    end
  endtask

  // inputs stable since last negedge; model advances over one posedge
  task automatic step(string req);
    model = next_val(model, clr_n, load_n, data, cnt_par, cnt_trk);
    @(posedge clk);
    @(negedge clk);
    check_cnt(req, model);
    check_flag(req, exp_flag(model, cnt_trk));
  endtask

  task automatic drive(logic c_n, logic l_n, logic [W-1:0] d, logic p, logic t);
    clr_n = c_n; load_n = l_n; data = d; cnt_par = p; cnt_trk = t;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    drive(1'b0, 1'b1, '0, 1'b1, 1'b1);
    model = '0;
    @(negedge clk);
    check_cnt("R1 reset", '0);
    check_flag("R1 reset", 1'b0);
    drive(1'b1, 1'b1, '0, 1'b0, 1'b0);

    // R2: load with both enables low
    drive(1'b1, 1'b0, 16'h1234, 1'b0, 1'b0);
    step("R2 load enables low");
    // R4: par low holds
    drive(1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b1);
    step("R4 par low hold");
    // R4: trk low holds
    drive(1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0);
    step("R4 trk low hold");
    // R3
    drive(1'b1, 1'b1, 16'h0000, 1'b1, 1'b1);
    step("R3 increment");
    // R7: slice boundaries
    drive(1'b1, 1'b0, 16'h00FF, 1'b0, 1'b1);
    step("R2 load 00FF");
    drive(1'b1, 1'b1, 16'h0000, 1'b1, 1'b1);
    step("R7 carry 00FF->0100");
    check_cnt("R7 boundary", 16'h0100);
    drive(1'b1, 1'b0, 16'h0FFF, 1'b1, 1'b1);
    step("R2 load 0FFF enables high");
    drive(1'b1, 1'b1, 16'h0000, 1'b1, 1'b1);
    step("R7 carry 0FFF->1000");
    check_cnt("R7 boundary", 16'h1000);
    // R6 / R8 at all ones
    drive(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1);
    step("R2 load FFFF");
    check_flag("R6 flag at max", 1'b1);
    cnt_par = 1'b1; #1;
    check_flag("R6 par no effect", 1'b1);
    cnt_par = 1'b0; #1;
    check_flag("R6 par no effect low", 1'b1);
    load_n = 1'b1; cnt_trk = 1'b0; #1;
    check_flag("R8 trk drop same cycle", 1'b0);
    cnt_trk = 1'b1; #1;
    check_flag("R8 trk rise same cycle", 1'b1);
    // R5 wrap
    drive(1'b1, 1'b1, 16'h0000, 1'b1, 1'b1);
    step("R5 wrap");
    check_cnt("R5 wrap zero", 16'h0000);
    // R1 mid-cycle async clear
    drive(1'b1, 1'b0, 16'hABCD, 1'b1, 1'b1);
    step("R2 load ABCD");
    @(posedge clk); #3;
    model = next_val(model, clr_n, load_n, data, cnt_par, cnt_trk);
    clr_n = 1'b0; #2;
    model = '0;
    check_cnt("R1 async clear", '0);
    step("R1 clear over load");
    drive(1'b1, 1'b1, '0, 1'b0, 1'b0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive((r != 0), ($urandom_range(0, 9) != 0), W'($urandom),
            ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0));
      if (i % 50 == 0) begin
        data = 16'hFFFE + W'(i % 2);
        load_n = 1'b0;
      end
      step("R3 R4 R7 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule